// File: doc/BRIEF.md
# HDLC Flag Carrier Detector

This block decides whether a packet channel is busy by watching the decoded receive bits for HDLC framing, not for signal energy. Bits arrive sixteen at a time on `word_bits`, qualified by a one-cycle `word_valid` strobe. Bit 0 of each word is the earliest bit received.

A signed credit counter sets the `dcd` output. When a flag octet appears anywhere in the recent bit history, the counter is reloaded to a large value. Each run of eight ones, which is an abort or plain noise, drains a large amount from the counter. Every word drains a small fixed amount. A receiver or transmit arbiter uses `dcd` as its channel-busy indication. `MAXFLEN`, the longest expected frame in words, sets the reload and drain sizes.

Top module: `hdlc_flag_dcd`

## Requirements
- R1: After reset, `dcd` is low, the credit counter is zero and the stored previous-word bits are all zero.
- R2: Bit 0 of `word_bits` is the earliest bit. On each strobe, an 8-bit window is tested at all 16 alignments, each ending on one bit of the new word. The lowest seven alignments reach back into the last seven bits of the previous accepted word, so a pattern that straddles two words is found.
- R3: A flag is the window value 0,1,1,1,1,1,1,0 in arrival order (8'h7E). If any alignment holds a flag, the counter is first set to MAXFLEN+4.
- R4: An abort is a window of eight ones. The alignments are visited from earliest to latest. Each abort subtracts MAXFLEN-10, but only while the counter is not negative at that point in the sequence.
- R5: After the flag and abort steps, the counter drops by 2 if it is not negative.
- R6: A negative counter is left unchanged by any word without a flag, so only a flag can end the negative state.
- R7: `dcd` is high exactly when the counter, as updated by the most recent strobe, is greater than zero. It changes on the clock edge that accepts the strobe.
- R8: Cycles without `word_valid` change neither `dcd`, the counter nor the stored previous bits, whatever `word_bits` carries.
- R9: The flag step comes before the abort step. A word holding one flag and one abort alignment leaves the counter at 12 and `dcd` high.
- R10: The counter always stays within -(MAXFLEN-10) to MAXFLEN+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | One-cycle strobe: `word_bits` holds a new word |
| word_bits | input | 16 | Received bits, bit 0 earliest |
| dcd | output | 1 | Carrier detected (counter above zero) |

## Verification
Two situations are hard to reach from the ports. One is a single word that holds a flag and also one or more eight-ones runs, so that the flag-then-abort order and the stop-at-negative rule decide the outcome. The other is a flag split across a word boundary. The bench sets up both with directed words (for example 16'hFF7E followed by 16'hFFFF, and 16'hC000 followed by 16'h000F). It also plants flags at random offsets and mixes them with all-ones and all-zeros words in the random phase. A long run of flag-free words then walks the counter down through zero into the sticky negative region, where the only way out is a reload.

// File: rtl/hdlc_flag_dcd.sv
module hdlc_flag_dcd #(
  parameter int MAXFLEN = 400,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_bits,
  output logic              dcd
);
  localparam int WIN  = 8;
  localparam int HW   = WORD_W + WIN - 1;
  localparam int CW   = $clog2(MAXFLEN + 5) + 2;
  localparam logic signed [CW-1:0] LOAD  = CW'(MAXFLEN + 4);
  localparam logic signed [CW-1:0] DRAIN = CW'(MAXFLEN - 10);
  localparam logic signed [CW-1:0] DECAY = CW'(2);

  logic [WIN-2:0]          prev_q;
  logic signed [CW-1:0]    cnt_q, cnt_d;
  logic [HW-1:0]           hist;
  logic [WORD_W-1:0]       flag_vec, abort_vec;
  logic                    flag_hit, abort_hit;

  assign hist = {word_bits, prev_q};

  for (genvar i = 0; i < WORD_W; i++) begin : g_align
    assign flag_vec[i]  = hist[i +: WIN] == 8'h7E;
    assign abort_vec[i] = &hist[i +: WIN];
  end

  assign flag_hit  = |flag_vec;
  assign abort_hit = |abort_vec;

  always_comb begin
    cnt_d = flag_hit ? LOAD : cnt_q;
    for (int i = 0; i < WORD_W; i++)
      if (abort_vec[i] && !cnt_d[CW-1]) cnt_d = cnt_d - DRAIN;
    if (!cnt_d[CW-1]) cnt_d = cnt_d - DECAY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else if (word_valid) begin
      cnt_q  <= cnt_d;
      prev_q <= word_bits[WORD_W-1 -: WIN-1];
    end
  end

  assign dcd = !cnt_q[CW-1] && (cnt_q != '0);
endmodule

// File: rtl/hdlc_flag_dcd_chk.sv
module hdlc_flag_dcd_chk #(
  parameter int MAXFLEN = 400,
  parameter int CW      = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 word_valid,
  input logic                 flag_hit,
  input logic                 abort_hit,
  input logic signed [CW-1:0] cnt_q,
  input logic                 dcd
);
  p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= $signed(CW'(MAXFLEN + 4))) && (cnt_q >= -$signed(CW'(MAXFLEN - 10))));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(cnt_q) && $stable(dcd));

  p_flag_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && flag_hit && !abort_hit |=> cnt_q == $signed(CW'(MAXFLEN + 2)) && dcd);

  p_decay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !flag_hit && !abort_hit && !cnt_q[CW-1] |=> cnt_q == $past(cnt_q) - $signed(CW'(2)));

  p_neg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !flag_hit && cnt_q[CW-1] |=> cnt_q == $past(cnt_q) && !dcd);
endmodule

bind hdlc_flag_dcd hdlc_flag_dcd_chk #(.MAXFLEN(MAXFLEN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .flag_hit(flag_hit),
  .abort_hit(abort_hit), .cnt_q(cnt_q), .dcd(dcd)
);

// File: tb/hdlc_flag_dcd_tb.sv
module hdlc_flag_dcd_tb;
  localparam int MAXF = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [15:0] word_bits = '0;
  logic        dcd;

  int n_cmp = 0;
  int n_bad = 0;
  int m_cnt = 0;
  logic [15:0] m_prev = '0;
  bit done = 0;

  always #10 clk = ~clk;

  hdlc_flag_dcd #(.MAXFLEN(MAXF)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid),
    .word_bits(word_bits), .dcd(dcd)
  );

  function automatic int model_step(int c, logic [15:0] p, logic [15:0] w);
    logic [31:0] s;
    bit f;
    s = {w, p};
    f = 0;
    for (int i = 0; i < 16; i++) if (s[9+i +: 8] == 8'h7E) f = 1;
    if (f) c = MAXF + 4;
    for (int i = 0; i < 16; i++)
      if (s[9+i +: 8] == 8'hFF && c >= 0) c = c - (MAXF - 10);
    if (c >= 0) c = c - 2;
    return c;
  endfunction

  task automatic check(logic got, logic exp, string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: dcd=%0b expected %0b (model count %0d)", req, got, exp, m_cnt);
    end
  endtask

  task automatic burst(logic [15:0] w, string req);
    @(negedge clk);
    word_bits  = w;
    word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    word_bits  = 16'($urandom);
    m_cnt  = model_step(m_cnt, m_prev, w);
    m_prev = w;
    check(dcd, m_cnt > 0, req);
  endtask

  initial begin
    logic held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(dcd, 1'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(dcd, 1'b0, "R1 after release");

    // R2: flag straddling the word boundary
    burst(16'hC000, "R2 lead-in");
    burst(16'h000F, "R2 boundary flag");
    // R3: plain flag reload
    burst(16'h007E, "R3 flag");
    // R5/R7: decay to zero after 201 empty words
    for (int k = 0; k < 201; k++) burst(16'h0000, "R5 decay");
    check(dcd, 1'b0, "R7 low at zero");
    // R6: negative stays, only a flag ends it
    for (int k = 0; k < 5; k++) burst(16'h5555, "R6 negative hold");
    // R9: flag and one abort in one word
    burst(16'hFF7E, "R9 flag before abort");
    check(dcd, 1'b1, "R9 still high");
    for (int k = 0; k < 5; k++) burst(16'h0000, "R9 small credit");
    // R4: many aborts, stop at negative
    burst(16'hFFFF, "R4 abort drain");
    check(dcd, 1'b0, "R4 low");
    // R8: idle cycles with garbage on the bus
    burst(16'hC07E, "R8 setup");
    held = dcd;
    repeat (6) begin
      @(negedge clk);
      word_bits = 16'($urandom);
      check(dcd, held, "R8 idle");
    end
    burst(16'h000F, "R8 previous bits kept");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] w;
      int sel, off;
      sel = $urandom_range(0, 9);
      w = 16'($urandom);
      if (sel < 3) begin
        off = $urandom_range(0, 8);
        w = (w & ~(16'h00FF << off)) | (16'h007E << off);
      end else if (sel < 5) w = 16'hFFFF;
      else if (sel < 7) w = 16'h0000;
      burst(w, "R7 random");
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule